// File: doc/BRIEF.md
# Boolean Flag Bank with Bulk Transfer

This block keeps a set of one-bit Boolean flags that a processor pipeline fills from its compare results and consults when deciding whether an operation is enabled. A flag holding 1 means true and a flag holding 0 means false. There are 64 flags by default, selected with a 6-bit index. Flag 0 is a constant true entry: it always reads as 1, and anything written to it disappears without any error indication.

Two independent read ports return flag values combinationally from their indices. Two write ports update flags on the rising clock edge, so a single compare can deposit both its result and the complement of that result in the same cycle. For context switches the complete bank is always visible as one 64-bit word, bit i holding flag i. The whole bank can also be reloaded from one 64-bit word in a single cycle. The lowest sixteen flags behave as plain storage. Flags 16 to 63 are also plain storage here, because no rotation or renaming is applied to them.

Top module: `pred_file`

## Requirements
- R1: A synchronous active-high reset leaves flags 1 to 63 at 0. Reset takes priority over every write and over a restore in the same cycle, so the save word reads 64'h1 afterwards.
- R2: Reading index 0 on either read port returns 1 at all times.
- R3: A write that targets index 0 on either port changes no flag and no output, and it raises no signal.
- R4: A write on an enabled port stores its value at the next rising edge. Reads are combinational, so the new value is visible right after that edge.
- R5: When the two ports write different indices in one cycle, both writes take effect.
- R6: When both ports write the same nonzero index in one cycle, the value on write port 1 is stored.
- R7: Asserting the restore strobe loads flags 1 to 63 from bits 1 to 63 of the restore word in one cycle. Bit 0 of the restore word is ignored.
- R8: A restore in the same cycle as single-bit writes overrides those writes.
- R9: Bit i of the save word always equals flag i, and bit 0 is always 1.
- R10: A write port whose enable is low changes nothing, whatever its index and value inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 6 | Index for read port A |
| rd_a_val | output | 1 | Flag value at rd_a_idx |
| rd_b_idx | input | 6 | Index for read port B |
| rd_b_val | output | 1 | Flag value at rd_b_idx |
| wr0_en | input | 1 | Enable for write port 0 |
| wr0_idx | input | 6 | Target index for write port 0 |
| wr0_val | input | 1 | Data for write port 0 |
| wr1_en | input | 1 | Enable for write port 1, which has priority over port 0 |
| wr1_idx | input | 6 | Target index for write port 1 |
| wr1_val | input | 1 | Data for write port 1 |
| restore_en | input | 1 | Reload the whole bank from restore_word |
| restore_word | input | 64 | Incoming bank image; bit i goes to flag i, bit 0 is ignored |
| save_word | output | 64 | Current bank image; bit i is flag i |

## Verification
The hardest case to reach from the ports is a single cycle in which a restore, two single-bit writes and possibly a reset all compete for the same flags. Only that case shows whether the priority chain is ordered correctly. The stimulus drives a restore image in which the flags targeted by both write ports hold the opposite value to the write data. It then reads those flags back and compares the full save word. A separate step asserts reset while a restore and writes are pending, so that reset can be seen to win.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int unsigned NUM_PRED_DEF = 64;
  localparam int unsigned NUM_WR_PORTS = 2;

  typedef struct packed {
    logic en;
    logic val;
  } wr_ctl_t;
endpackage

// File: rtl/pred_wr_decode.sv
module pred_wr_decode #(
  parameter int unsigned NUM_PRED = 64,
  localparam int unsigned IDX_W = $clog2(NUM_PRED)
) (
  input  logic                en,
  input  logic [IDX_W-1:0]    idx,
  output logic [NUM_PRED-1:0] sel
);
  // One-hot select; entry 0 is never selected, so writes to it vanish.
  assign sel[0] = 1'b0;
  for (genvar i = 1; i < NUM_PRED; i++) begin : g_sel
    assign sel[i] = en && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/pred_bank.sv
module pred_bank #(
  parameter int unsigned NUM_PRED = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PRED-1:0] sel0,
  input  logic                val0,
  input  logic [NUM_PRED-1:0] sel1,
  input  logic                val1,
  input  logic                restore_en,
  input  logic [NUM_PRED-1:0] restore_word,
  output logic [NUM_PRED-1:0] image
);
  logic [NUM_PRED-1:1] flags;

  for (genvar i = 1; i < NUM_PRED; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flags[i] <= 1'b0;
      else if (restore_en) flags[i] <= restore_word[i];
      else if (sel1[i])    flags[i] <= val1;
      else if (sel0[i])    flags[i] <= val0;
    end
  end

  assign image = {flags, 1'b1};

  // R1: reset clears every writable flag
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (flags == '0));

  // R7: restore loads bits 1 upward in one cycle
  a_r7_restore_loads: assert property (@(posedge clk) disable iff (rst)
    restore_en |=> (flags == $past(restore_word[NUM_PRED-1:1])));

  // R10: no write or restore leaves the bank untouched
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!restore_en && (sel0 == '0) && (sel1 == '0)) |=> $stable(flags));
endmodule

// File: rtl/pred_rd_port.sv
module pred_rd_port #(
  parameter int unsigned NUM_PRED = 64,
  localparam int unsigned IDX_W = $clog2(NUM_PRED)
) (
  input  logic [NUM_PRED-1:0] image,
  input  logic [IDX_W-1:0]    idx,
  output logic                val
);
  assign val = image[idx];
endmodule

// File: rtl/pred_file.sv
module pred_file #(
  parameter int unsigned NUM_PRED = pred_pkg::NUM_PRED_DEF,
  localparam int unsigned IDX_W = $clog2(NUM_PRED)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    rd_a_idx,
  output logic                rd_a_val,
  input  logic [IDX_W-1:0]    rd_b_idx,
  output logic                rd_b_val,
  input  logic                wr0_en,
  input  logic [IDX_W-1:0]    wr0_idx,
  input  logic                wr0_val,
  input  logic                wr1_en,
  input  logic [IDX_W-1:0]    wr1_idx,
  input  logic                wr1_val,
  input  logic                restore_en,
  input  logic [NUM_PRED-1:0] restore_word,
  output logic [NUM_PRED-1:0] save_word
);
  import pred_pkg::*;

  wr_ctl_t [NUM_WR_PORTS-1:0]   ctl;
  logic    [IDX_W-1:0]          idx_arr [NUM_WR_PORTS];
  logic    [NUM_PRED-1:0]       sel_arr [NUM_WR_PORTS];

  assign ctl[0]     = '{en: wr0_en, val: wr0_val};
  assign ctl[1]     = '{en: wr1_en, val: wr1_val};
  assign idx_arr[0] = wr0_idx;
  assign idx_arr[1] = wr1_idx;

  for (genvar p = 0; p < NUM_WR_PORTS; p++) begin : g_dec
    pred_wr_decode #(.NUM_PRED(NUM_PRED)) i_dec (
      .en  (ctl[p].en),
      .idx (idx_arr[p]),
      .sel (sel_arr[p])
    );
  end

  pred_bank #(.NUM_PRED(NUM_PRED)) i_bank (
    .clk          (clk),
    .rst          (rst),
    .sel0         (sel_arr[0]),
    .val0         (ctl[0].val),
    .sel1         (sel_arr[1]),
    .val1         (ctl[1].val),
    .restore_en   (restore_en),
    .restore_word (restore_word),
    .image        (save_word)
  );

  pred_rd_port #(.NUM_PRED(NUM_PRED)) i_rd_a (
    .image (save_word), .idx (rd_a_idx), .val (rd_a_val));
  pred_rd_port #(.NUM_PRED(NUM_PRED)) i_rd_b (
    .image (save_word), .idx (rd_b_idx), .val (rd_b_val));

  // R2: index 0 reads true on both ports
  a_r2_zero_true: assert property (@(posedge clk) disable iff (rst)
    ((rd_a_idx == '0) |-> rd_a_val) and ((rd_b_idx == '0) |-> rd_b_val));

  // R3: writes aimed only at index 0 leave the image unchanged
  a_r3_zero_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (!restore_en && (wr0_en || wr1_en) &&
     (!wr0_en || wr0_idx == '0) && (!wr1_en || wr1_idx == '0))
    |=> $stable(save_word));

  // R6: port 1 wins on a shared nonzero index
  a_r6_port1_priority: assert property (@(posedge clk) disable iff (rst)
    (!restore_en && wr0_en && wr1_en && wr0_idx == wr1_idx && wr1_idx != '0)
    |=> (save_word[$past(wr1_idx)] == $past(wr1_val)));

  // R4: single write lands at the next edge
  a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
    (!restore_en && wr0_en && !wr1_en && wr0_idx != '0)
    |=> (save_word[$past(wr0_idx)] == $past(wr0_val)));

  // R9: save image bit 0 stays set after reset
  a_r9_bit0_set: assert property (@(posedge clk) disable iff (rst)
    save_word[0]);
endmodule

// File: tb/test_pred_file.sv
`timescale 1ns/1ps
module test_pred_file;
  localparam int N = 64;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst;
  logic [5:0] rd_a_idx, rd_b_idx, wr0_idx, wr1_idx;
  logic rd_a_val, rd_b_val, wr0_en, wr0_val, wr1_en, wr1_val, restore_en;
  logic [N-1:0] restore_word, save_word;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  pred_file i_pred_file (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_val(rd_a_val),
    .rd_b_idx(rd_b_idx), .rd_b_val(rd_b_val),
    .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_val(wr0_val),
    .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_val(wr1_val),
    .restore_en(restore_en), .restore_word(restore_word),
    .save_word(save_word)
  );

  // {w0en,w0idx,w0val, w1en,w1idx,w1val, rdA idx,expA, rdB idx,expB}
  localparam logic [29:0] VEC [NV] = '{
    {1'b1,6'd5,1'b1,  1'b0,6'd0,1'b0,  6'd5,1'b1,  6'd0,1'b1},  // R4 R2
    {1'b1,6'd7,1'b1,  1'b1,6'd63,1'b1, 6'd7,1'b1,  6'd63,1'b1}, // R5
    {1'b1,6'd9,1'b1,  1'b1,6'd9,1'b0,  6'd9,1'b0,  6'd5,1'b1},  // R6
    {1'b1,6'd9,1'b0,  1'b1,6'd9,1'b1,  6'd9,1'b1,  6'd7,1'b1},  // R6
    {1'b1,6'd0,1'b0,  1'b1,6'd0,1'b0,  6'd0,1'b1,  6'd0,1'b1},  // R3
    {1'b0,6'd5,1'b0,  1'b0,6'd7,1'b0,  6'd5,1'b1,  6'd7,1'b1},  // R10
    {1'b1,6'd63,1'b0, 1'b1,6'd15,1'b1, 6'd63,1'b0, 6'd15,1'b1}, // R5
    {1'b1,6'd1,1'b1,  1'b0,6'd2,1'b1,  6'd1,1'b1,  6'd2,1'b0}   // R4 R10
  };

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr0_en = 0; wr1_en = 0; restore_en = 0;
    wr0_idx = 0; wr1_idx = 0; wr0_val = 0; wr1_val = 0;
    restore_word = '0;
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    idle();
    rst = 1; rd_a_idx = 0; rd_b_idx = 6'd40;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check("R1 save after reset", save_word, 64'h1);
    check("R1 flag 40 cleared", {63'd0, rd_b_val}, 64'd0);
    check("R2 idx0 after reset", {63'd0, rd_a_val}, 64'd1);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {wr0_en, wr0_idx, wr0_val, wr1_en, wr1_idx, wr1_val} = VEC[v][29:14];
      @(posedge clk); #1;
      idle();
      rd_a_idx = VEC[v][13:8];
      rd_b_idx = VEC[v][6:1];
      #0.5;
      check($sformatf("R4/R5/R6/R3/R10 vec%0d portA", v), {63'd0, rd_a_val}, {63'd0, VEC[v][7]});
      check($sformatf("R4/R5/R6/R3/R10 vec%0d portB", v), {63'd0, rd_b_val}, {63'd0, VEC[v][0]});
    end

    // R9: image matches flags 0,1,5,7,9,15
    @(negedge clk);
    check("R9 save image", save_word, 64'h82A3);

    // R7 R8: restore beats writes aimed at 16 and 17
    @(negedge clk);
    restore_en = 1; restore_word = 64'hA5A5_0000_FFFF_0000;
    wr0_en = 1; wr0_idx = 6'd16; wr0_val = 0;
    wr1_en = 1; wr1_idx = 6'd17; wr1_val = 0;
    @(posedge clk); #1;
    idle();
    rd_a_idx = 6'd16; rd_b_idx = 6'd17;
    #0.5;
    check("R8 restore wins port0", {63'd0, rd_a_val}, 64'd1);
    check("R8 restore wins port1", {63'd0, rd_b_val}, 64'd1);
    check("R7 R9 restore image bit0 forced", save_word, 64'hA5A5_0000_FFFF_0001);

    // R7: all-zero image, bit 0 still true
    @(negedge clk);
    restore_en = 1; restore_word = '0;
    @(posedge clk); #1;
    idle(); rd_a_idx = 0; #0.5;
    check("R7 zero restore", save_word, 64'h1);
    check("R2 idx0 after zero restore", {63'd0, rd_a_val}, 64'd1);

    // R7: all-ones image including bit 0
    @(negedge clk);
    restore_en = 1; restore_word = '1;
    @(posedge clk); #1;
    idle(); #0.5;
    check("R7 ones restore", save_word, '1);

    // R3: write 0 to index 0 with all flags set
    @(negedge clk);
    wr0_en = 1; wr0_idx = 0; wr0_val = 0;
    @(posedge clk); #1;
    idle(); rd_b_idx = 0; #0.5;
    check("R3 idx0 write dropped", save_word, '1);
    check("R3 idx0 reads true", {63'd0, rd_b_val}, 64'd1);

    // R1: reset beats restore and writes
    @(negedge clk);
    rst = 1; restore_en = 1; restore_word = '1;
    wr0_en = 1; wr0_idx = 6'd3; wr0_val = 1;
    @(posedge clk); #1;
    rst = 0; idle(); #0.5;
    check("R1 reset priority", save_word, 64'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule